// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block is the host-visible control window for two IDE bus-master DMA channels. Software reaches it over a simple register bus: a word index, byte enables and 32-bit write data. Read data is returned combinationally in the same cycle. The window is 16 bytes long, split into two 8-byte halves with the same layout. Each half holds a command byte, a shared mode byte, a status byte and a per-channel timing byte in its first word. Its second word holds a 32-bit descriptor-table pointer. The bus has no stall: every access with `bus_valid` high completes in the cycle it is presented, so the block never applies back-pressure.

For each channel, the block turns command writes into single-cycle start and cancel pulses for the data mover. It tracks the channel's active, error and interrupt status flags, and it presents the stored descriptor pointer. It also merges the two drive-channel interrupt levels into one shared interrupt line, and each channel has a mask bit that software controls. The vendor extension bytes (the mode byte and the timing bytes) can be removed with a parameter. When they are removed, those lanes read as all ones.

Top module: `bmdma_regs`

## Requirements
- R1: Word index 0 is channel 0 control, 1 is channel 0 pointer, 2 is channel 1 control, 3 is channel 1 pointer. The control word lanes are: byte 0 command, byte 1 mode, byte 2 status, byte 3 timing. A write to one channel never changes the other channel's command, status, timing or pointer, and never pulses its outputs.
- R2: A command-byte write with bit 0 clear raises `cancel_o` for that channel in the cycle after the write. It also clears the active status bit (bit 0), and it stores the written value ANDed with 0x09.
- R3: A command-byte write with bit 0 set works as follows. If the active bit was clear, the block raises `start_o` in the cycle after the write and sets the active bit. If the active bit was already set, there is no pulse. In both cases the value ANDed with 0x09 is stored.
- R4: A status-byte write copies data bits 6 and 5 into status bits 6 and 5. A 1 in data bit 1 or bit 2 clears status bit 1 (error) or status bit 2 (interrupt). Bit 0 is left unchanged, and bits 7, 4 and 3 always read 0. A high `xfer_err_i` sets bit 1 and a high `xfer_intr_i` sets bit 2, and a set in the same cycle as a clear wins.
- R5: A high `xfer_done_i` clears that channel's active bit.
- R6: In the mode byte, bits 2 and 3 show the levels of `chan_irq_i[0]` and `chan_irq_i[1]`, one cycle after each input changes. A mode-byte write through either channel changes only bits 5:4 (the channel 0 and channel 1 mask bits). All other mode bits read 0.
- R7: `irq_o` = (bit2 AND NOT bit4) OR (bit3 AND NOT bit5) of the mode byte.
- R8: Each channel has its own read/write timing byte.
- R9: The pointer word accepts any combination of byte enables, and only the enabled lanes change. Bits 1:0 always read 0. The channel's `desc_ptr*_o` output shows the stored value from the cycle after the write.
- R10: Reset clears command, status, mode, timing and pointer to 0. `cancel_o` is 2'b11 while reset is held and for the cycle after it is released, then 2'b00, and `start_o` stays 0 throughout.
- R11: With `VENDOR_EXT` = 0, bytes 1 and 3 of the control words read 0xFF and writes to them have no effect, so the mask bits stay 0 and `irq_o` follows any pending input.
- R12: `start_o` and `cancel_o` are single-cycle pulses, and they are never high together on the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 2 | Word index within the 16-byte window |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data, lane-aligned |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| xfer_done_i | input | 2 | Per-channel transfer-complete pulse |
| xfer_err_i | input | 2 | Per-channel error-flag set |
| xfer_intr_i | input | 2 | Per-channel interrupt-flag set |
| chan_irq_i | input | 2 | Drive-channel interrupt levels |
| start_o | output | 2 | Per-channel start pulse |
| cancel_o | output | 2 | Per-channel cancel pulse |
| desc_ptr0_o | output | 32 | Channel 0 descriptor pointer |
| desc_ptr1_o | output | 32 | Channel 1 descriptor pointer |
| irq_o | output | 1 | Merged, masked interrupt |

## Verification
The bench sweeps all 256 command values and all 256 status values on each channel, with the active, error and interrupt flags in different states. This exposes a design that restarts a channel that is already running, or that keeps a command bit other than 0 and 3. It also exposes a design that lets a status write touch bit 0, or that treats the write-1-to-clear bits as plain writable bits. It then walks all mask and pending combinations of the mode byte, with the other bits of the written byte set. A design that lets software write the pending bits, or that inverts the masking, then drives the wrong level on `irq_o`. Every byte-enable pattern is applied to both pointers, which catches lane mix-ups, pointer bits 1:0 that are not forced to zero, and writes that leak into the other channel. A second instance built without the vendor extension shows that its lanes read as all ones and that mask writes there are ignored.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int NUM_CH    = 2;
  localparam int BYTE_W    = 8;
  localparam int LANE_CMD  = 0;
  localparam int LANE_MODE = 1;
  localparam int LANE_STAT = 2;
  localparam int LANE_TIM  = 3;

  typedef struct packed {
    logic cap6;
    logic cap5;
    logic intf;
    logic err;
    logic act;
  } bm_stat_t;

  function automatic logic [7:0] stat_byte(input bm_stat_t s);
    return {1'b0, s.cap6, s.cap5, 2'b00, s.intf, s.err, s.act};
  endfunction
endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic [1:0]         cmd_bits,
  input  logic               stat_we,
  input  logic [1:0]         stat_clr,
  input  logic [1:0]         stat_cap,
  input  logic               tim_we,
  input  logic [7:0]         tim_wdata,
  input  logic [PTR_W/8-1:0] ptr_be,
  input  logic [PTR_W-1:0]   ptr_wdata,
  input  logic               done_i,
  input  logic               err_i,
  input  logic               intr_i,
  output logic [7:0]         cmd_q,
  output logic [7:0]         stat_q,
  output logic [7:0]         tim_q,
  output logic [PTR_W-1:0]   ptr_q,
  output logic               start_o,
  output logic               cancel_o
);
  localparam int LANES = PTR_W / 8;
  localparam logic [PTR_W-1:0] PTR_KEEP = ~((PTR_W'(1) << ALIGN_BITS) - PTR_W'(1));

  bm_stat_t         st, st_n;
  logic [1:0]       cmd_r;
  logic [PTR_W-1:0] ptr_n;
  logic             start_n, cancel_n;

  always_comb begin
    st_n     = st;
    start_n  = 1'b0;
    cancel_n = 1'b0;
    if (cmd_we) begin
      if (!cmd_bits[0])  cancel_n = 1'b1;
      else if (!st.act)  start_n  = 1'b1;
    end
    if (stat_we) begin
      st_n.err  = st.err  & ~stat_clr[0];
      st_n.intf = st.intf & ~stat_clr[1];
      st_n.cap5 = stat_cap[0];
      st_n.cap6 = stat_cap[1];
    end
    if (err_i)  st_n.err  = 1'b1;
    if (intr_i) st_n.intf = 1'b1;
    if (start_n)                st_n.act = 1'b1;
    else if (cancel_n || done_i) st_n.act = 1'b0;
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign ptr_n[8*b +: 8] = ptr_be[b] ? ptr_wdata[8*b +: 8] : ptr_q[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= '0;
      cmd_r    <= '0;
      tim_q    <= '0;
      ptr_q    <= '0;
      start_o  <= 1'b0;
      cancel_o <= 1'b1;
    end else begin
      st       <= st_n;
      start_o  <= start_n;
      cancel_o <= cancel_n;
      if (cmd_we)  cmd_r <= cmd_bits;
      if (tim_we)  tim_q <= tim_wdata;
      if (|ptr_be) ptr_q <= ptr_n & PTR_KEEP;
    end
  end

  assign cmd_q  = {4'b0000, cmd_r[1], 2'b00, cmd_r[0]};
  assign stat_q = stat_byte(st);

  // R3: a start pulse only follows an idle channel and leaves it active
  p_start_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (st.act && !$past(st.act)));

  // R12: never start and cancel together
  p_no_start_cancel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && cancel_o));
endmodule

// File: rtl/bmdma_irq_merge.sv
module bmdma_irq_merge #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_irq_i,
  input  logic              mask_we,
  input  logic [NUM_CH-1:0] mask_wdata,
  output logic [7:0]        mode_q,
  output logic              irq_o
);
  localparam int PEND_LSB = 2;
  localparam int MASK_LSB = PEND_LSB + NUM_CH;

  logic [NUM_CH-1:0] pend, blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      blk  <= '0;
    end else begin
      pend <= chan_irq_i;
      if (mask_we) blk <= mask_wdata;
    end
  end

  always_comb begin
    mode_q = '0;
    mode_q[PEND_LSB +: NUM_CH] = pend;
    mode_q[MASK_LSB +: NUM_CH] = blk;
  end

  assign irq_o = |(pend & ~blk);

  // R6: pending bits track the inputs one cycle later
  p_pend_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pend == $past(chan_irq_i)));

  // R6: mask bits change only on a mode-byte write
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(blk));
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2,
  parameter bit VENDOR_EXT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [1:0]       bus_word,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [1:0]       xfer_done_i,
  input  logic [1:0]       xfer_err_i,
  input  logic [1:0]       xfer_intr_i,
  input  logic [1:0]       chan_irq_i,
  output logic [1:0]       start_o,
  output logic [1:0]       cancel_o,
  output logic [PTR_W-1:0] desc_ptr0_o,
  output logic [PTR_W-1:0] desc_ptr1_o,
  output logic             irq_o
);
  localparam int LANES = PTR_W / 8;

  logic [7:0]       cmd_a  [NUM_CH];
  logic [7:0]       stat_a [NUM_CH];
  logic [7:0]       tim_a  [NUM_CH];
  logic [PTR_W-1:0] ptr_a  [NUM_CH];
  logic [7:0]       mode_q;
  logic [7:0]       mode_rd;
  logic             ctl_wr_any;

  assign ctl_wr_any = bus_valid && bus_write && !bus_word[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ctl_we, ptr_we;
    assign ctl_we = ctl_wr_any && (bus_word[1] == c[0]);
    assign ptr_we = bus_valid && bus_write && bus_word[0] && (bus_word[1] == c[0]);

    bmdma_chan #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (ctl_we && bus_be[LANE_CMD]),
      .cmd_bits ({bus_wdata[3], bus_wdata[0]}),
      .stat_we  (ctl_we && bus_be[LANE_STAT]),
      .stat_clr (bus_wdata[18:17]),
      .stat_cap (bus_wdata[22:21]),
      .tim_we   (ctl_we && bus_be[LANE_TIM] && VENDOR_EXT),
      .tim_wdata(bus_wdata[31:24]),
      .ptr_be   (ptr_we ? bus_be[LANES-1:0] : '0),
      .ptr_wdata(bus_wdata[PTR_W-1:0]),
      .done_i   (xfer_done_i[c]),
      .err_i    (xfer_err_i[c]),
      .intr_i   (xfer_intr_i[c]),
      .cmd_q    (cmd_a[c]),
      .stat_q   (stat_a[c]),
      .tim_q    (tim_a[c]),
      .ptr_q    (ptr_a[c]),
      .start_o  (start_o[c]),
      .cancel_o (cancel_o[c])
    );
  end

  bmdma_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_irq_i(chan_irq_i),
    .mask_we   (ctl_wr_any && bus_be[LANE_MODE] && VENDOR_EXT),
    .mask_wdata(bus_wdata[13:12]),
    .mode_q    (mode_q),
    .irq_o     (irq_o)
  );

  assign desc_ptr0_o = ptr_a[0];
  assign desc_ptr1_o = ptr_a[1];
  assign mode_rd     = VENDOR_EXT ? mode_q : 8'hFF;

  always_comb begin
    if (bus_word[0]) begin
      bus_rdata = 32'(ptr_a[bus_word[1]]);
    end else begin
      bus_rdata = {(VENDOR_EXT ? tim_a[bus_word[1]] : 8'hFF),
                   stat_a[bus_word[1]], mode_rd, cmd_a[bus_word[1]]};
    end
  end

  // R4: reserved status bits never read back as 1
  p_stat_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_word[0]) |-> (bus_rdata[23] == 1'b0 && bus_rdata[20:19] == 2'b00));
endmodule

// File: tb/bmdma_regs_tb.sv
`timescale 1ns/1ps
module bmdma_regs_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_valid = 0, bus_write = 0;
  logic [1:0]  bus_word = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic [1:0]  done_i = 0, err_i = 0, intr_i = 0, cirq = 0;
  logic [31:0] rd_x, rd_n, p0, p1, q0, q1;
  logic [1:0]  st_x, cn_x, st_n, cn_n;
  logic        irq_x, irq_n;

  bmdma_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_word(bus_word), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rd_x),
    .xfer_done_i(done_i), .xfer_err_i(err_i), .xfer_intr_i(intr_i), .chan_irq_i(cirq),
    .start_o(st_x), .cancel_o(cn_x), .desc_ptr0_o(p0), .desc_ptr1_o(p1), .irq_o(irq_x));

  bmdma_regs #(.VENDOR_EXT(1'b0)) u_noext (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_word(bus_word), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rd_n),
    .xfer_done_i(done_i), .xfer_err_i(err_i), .xfer_intr_i(intr_i), .chan_irq_i(cirq),
    .start_o(st_n), .cancel_o(cn_n), .desc_ptr0_o(q0), .desc_ptr1_o(q1), .irq_o(irq_n));

  int ntot = 0, nfail = 0;
  logic [7:0]  m_cmd [2], m_tim [2];
  logic        m_act [2], m_err [2], m_int [2], m_c5 [2], m_c6 [2];
  logic [1:0]  m_blk, m_pend;
  logic [31:0] m_ptr [2];
  logic [1:0]  e_start, e_cancel;

  task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
    ntot++;
    if (a !== e) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  function automatic logic [7:0] e_stat(input int c);
    return {1'b0, m_c6[c], m_c5[c], 2'b00, m_int[c], m_err[c], m_act[c]};
  endfunction
  function automatic logic [31:0] e_word0(input int c);
    return {m_tim[c], e_stat(c), {2'b00, m_blk, m_pend, 2'b00}, m_cmd[c]};
  endfunction
  function automatic logic [31:0] e_word0_n(input int c);
    return {8'hFF, e_stat(c), 8'hFF, m_cmd[c]};
  endfunction

  task automatic bwr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    int c;
    c = w[1];
    e_start = 0; e_cancel = 0;
    if (!w[0]) begin
      if (be[0]) begin
        if (!d[0]) begin e_cancel[c] = 1; m_act[c] = 0; end
        else if (!m_act[c]) begin e_start[c] = 1; m_act[c] = 1; end
        m_cmd[c] = d[7:0] & 8'h09;
      end
      if (be[1]) m_blk = d[13:12];
      if (be[2]) begin
        m_err[c] = (m_err[c] & ~d[17]) | err_i[c];
        m_int[c] = (m_int[c] & ~d[18]) | intr_i[c];
        m_c5[c] = d[21]; m_c6[c] = d[22];
      end
      if (be[3]) m_tim[c] = d[31:24];
    end else begin
      for (int b = 0; b < 4; b++) if (be[b]) m_ptr[c][8*b +: 8] = d[8*b +: 8];
      m_ptr[c][1:0] = 2'b00;
    end
    bus_valid = 1; bus_write = 1; bus_word = w; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic brd(input logic [1:0] w);
    bus_valid = 1; bus_write = 0; bus_word = w;
    #1;
    bus_valid = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    ntot++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = 0; m_tim[c] = 0; m_act[c] = 0; m_err[c] = 0; m_int[c] = 0;
      m_c5[c] = 0; m_c6[c] = 0; m_ptr[c] = 0;
    end
    m_blk = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    chk("R10 cancel held in reset", 32'(cn_x), 32'h3);
    rst_n = 1'b1;
    chk("R10 cancel after release", 32'(cn_x), 32'h3);
    chk("R10 no start", 32'(st_x), 32'h0);
    @(negedge clk);
    chk("R10 cancel pulse ends", 32'(cn_x), 32'h0);
    for (int w = 0; w < 4; w++) begin
      brd(2'(w));
      chk("R10 reset read", rd_x, 32'h0);
    end

    // R8 / R1: independent timing bytes
    bwr(2'b00, 4'b1000, 32'h5A00_0000);
    bwr(2'b10, 4'b1000, 32'hC300_0000);
    brd(2'b00); chk("R8 ch0 timing", rd_x, e_word0(0));
    brd(2'b10); chk("R8 R1 ch1 timing", rd_x, e_word0(1));

    // R2 / R3 / R12 / R1: command sweep
    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < 256; v++) begin
        bwr({1'(c), 1'b0}, 4'b0001, 32'(v));
        chk("R3 start pulse", 32'(st_x), 32'(e_start));
        chk("R2 cancel pulse", 32'(cn_x), 32'(e_cancel));
        brd({1'(c), 1'b0}); chk("R2 R3 command/status", rd_x, e_word0(c));
        brd({1'(1 - c), 1'b0}); chk("R1 other channel", rd_x, e_word0(1 - c));
        @(negedge clk);
        chk("R12 pulses one cycle", {30'd0, st_x | cn_x}, 32'h0);
      end
    end

    // R5: done clears active
    bwr(2'b00, 4'b0001, 32'h1);
    done_i = 2'b01; m_act[0] = 0;
    @(negedge clk); done_i = 0;
    brd(2'b00); chk("R5 done clears active", rd_x, e_word0(0));
    brd(2'b10); chk("R5 other channel untouched", rd_x, e_word0(1));

    // R4: status sweep with flags set before each write
    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < 256; v++) begin
        err_i[c] = 1; intr_i[c] = 1; m_err[c] = 1; m_int[c] = 1;
        @(negedge clk); err_i = 0; intr_i = 0;
        bwr({1'(c), 1'b0}, 4'b0100, 32'(v) << 16);
        brd({1'(c), 1'b0}); chk("R4 status write", rd_x, e_word0(c));
      end
    end
    // R4: set wins over same-cycle clear
    err_i = 2'b01;
    bwr(2'b00, 4'b0100, 32'h0006_0000);
    err_i = 0;
    brd(2'b00); chk("R4 set beats clear", rd_x, e_word0(0));

    // R6 / R7 / R11: mask and pending sweep
    for (int b = 0; b < 4; b++) begin
      bwr({1'(b & 1), 1'b0}, 4'b0010, 32'h0000_CF00 | (32'(b) << 12));
      for (int p = 0; p < 4; p++) begin
        cirq = 2'(p); m_pend = 2'(p);
        @(negedge clk);
        chk("R7 merged irq", 32'(irq_x),
            32'((m_pend[0] & ~m_blk[0]) | (m_pend[1] & ~m_blk[1])));
        chk("R11 irq unmasked", 32'(irq_n), 32'(|m_pend));
        brd(2'b10); chk("R6 mode byte", rd_x, e_word0(1));
        chk("R11 lanes read FF", rd_n, e_word0_n(1));
      end
    end
    cirq = 0; m_pend = 0;
    @(negedge clk);

    // R9: pointer byte enables
    for (int c = 0; c < 2; c++) begin
      for (int be = 1; be < 16; be++) begin
        bwr({1'(c), 1'b1}, 4'(be), 32'hA5C3_0F1B ^ (32'(be) * 32'h0103_0507) ^ 32'(c * 7));
        brd({1'(c), 1'b1}); chk("R9 pointer read", rd_x, m_ptr[c]);
        chk("R9 pointer output", (c == 0) ? p0 : p1, m_ptr[c]);
        chk("R1 other pointer", (c == 0) ? p1 : p0, m_ptr[1 - c]);
      end
    end

    // R11: timing write ignored without extension
    bwr(2'b00, 4'b1000, 32'h7700_0000);
    brd(2'b00);
    chk("R11 timing ignored", rd_n, e_word0_n(0));
    chk("R8 timing with extension", rd_x, e_word0(0));

    summary();
  end
endmodule